// File: doc/BRIEF.md
# Processor Sleep and Wake-up Controller

This block decides when a small processor core stops executing and when it starts again. The core signals three sleep-related actions with single-cycle strobes: a wait-for-interrupt request, a wait-for-event request and a send-event request. It also reports exception entry and exception return. The interrupt controller supplies a vector of pending, enabled requests and a 2-bit priority for each request. The core supplies its current execution priority, a flag that is low in thread mode, and a global interrupt hold level. Two control bits select extra behaviour. One turns every newly pending interrupt into a wake event. The other makes an exception return with nothing else pending go straight back to sleep.

Inside the block there is a one-bit event latch. It records that an event has happened, so that a later wait-for-event request can finish at once instead of sleeping. The two sleep kinds use different wake rules. An interrupt sleep ends only for a request more urgent than the current priority, or for a debug halt request. An event sleep ends on any event. On wake-up the block gives a one-cycle wake pulse. Alongside the pulse it gives a flag that tells the core whether to enter the pending handler or to resume at the instruction after the sleep request.

All the control inputs are plain levels or strobes. The block has no data stream, so no valid/ready handshake is involved.

Top module: `swk_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, sleeping_o, wake_o, take_irq_o and evt_latch_o are all 0.
- R2: While awake, an event sets evt_latch_o on the next cycle. The events are: send_evt_i, ext_evt_i, dbg_halt_i, exc_entry_i, exc_ret_i, an urgent pending request, or a pending bit rising while pend_evt_en_i is 1.
- R3: A wait_evt_i strobe while awake, when the latch is set or an event arrives in the same cycle, clears the latch on the next cycle. In that case sleeping_o stays 0 and no wake pulse is given.
- R4: A wait_evt_i strobe while awake, with the latch clear and no event in that cycle, raises sleeping_o on the next cycle. Any R2 event then ends the sleep, and evt_latch_o is 0 after the wake.
- R5: A wait_irq_i strobe raises sleeping_o on the next cycle. Only two things end this sleep: a debug halt, or a pending request that is urgent. A request is urgent when in_handler_i is 0 (thread mode, less urgent than any level) or when its priority is numerically lower than cur_prio_i (0 is the most urgent). Same-priority requests, lower-priority requests and other events leave the core asleep, but those events still set the latch.
- R6: With pend_evt_en_i at 1, a newly pending request of the same or lower priority ends an event sleep with take_irq_o at 0.
- R7: A wake caused by an urgent request gives take_irq_o at 1, unless irq_hold_i is 1, in which case take_irq_o is 0.
- R8: An exc_ret_i strobe with auto_sleep_en_i at 1 and no pending bit raises sleeping_o on the next cycle, and the interrupt-sleep wake rules of R5 then apply. If any pending bit is set, the core stays awake.
- R9: A wake condition present at a clock edge drops sleeping_o and raises wake_o on that edge. wake_o lasts exactly one cycle, and take_irq_o is 1 only during wake_o.
- R10: A debug halt request ends either kind of sleep, with take_irq_o at 0.
- R11: Asserting the asynchronous reset during sleep drops sleeping_o at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_irq_i | input | 1 | Wait-for-interrupt strobe |
| wait_evt_i | input | 1 | Wait-for-event strobe |
| send_evt_i | input | 1 | Send-event strobe |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_ret_i | input | 1 | Exception return strobe |
| irq_pend_i | input | NIRQ | Pending and enabled interrupt requests |
| irq_prio_i | input | NIRQ*PW | Priority of each request, request i at bits i*PW upward |
| in_handler_i | input | 1 | 1 in a handler, 0 in thread mode |
| cur_prio_i | input | PW | Current execution priority |
| irq_hold_i | input | 1 | Global interrupt hold level |
| pend_evt_en_i | input | 1 | Newly pending request counts as an event |
| auto_sleep_en_i | input | 1 | Sleep on exception return |
| dbg_halt_i | input | 1 | Debug halt request |
| ext_evt_i | input | 1 | External event input |
| sleeping_o | output | 1 | Core is asleep |
| wake_o | output | 1 | One-cycle wake pulse |
| take_irq_o | output | 1 | With wake_o: 1 to enter the handler, 0 to resume after the sleep request |
| evt_latch_o | output | 1 | Event latch state |

## Verification
Every result of this block comes from a register. Inputs applied in one cycle therefore show up on sleeping_o, wake_o, take_irq_o and evt_latch_o exactly one edge later. The driver sets inputs on the falling edge and queues the expected output set for the next rising edge. The monitor pops that item one time unit after that rising edge and compares all four outputs. The reset checks work differently, because the reset is asynchronous: the bench samples them directly while reset is held low, with no edge involved.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_SLP_IRQ = 2'd1,
    ST_SLP_EVT = 2'd2
  } swk_state_e;
endpackage

// File: rtl/swk_irq_qual.sv
module swk_irq_qual #(
  parameter int NIRQ = 4,
  parameter int PW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ*PW-1:0] irq_prio_i,
  input  logic            in_handler_i,
  input  logic [PW-1:0]   cur_prio_i,
  output logic            urgent_o,
  output logic            new_pend_o
);
  logic [NIRQ-1:0] hit;
  logic [NIRQ-1:0] pend_q;

  // a request outranks the core when the core is in thread mode or the
  // request's number is strictly smaller than the running level
  for (genvar i = 0; i < NIRQ; i++) begin : g_req
    logic [PW-1:0] pr;
    assign pr     = irq_prio_i[i*PW +: PW];
    assign hit[i] = irq_pend_i[i] & (~in_handler_i | (pr < cur_prio_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_pend_i;
  end

  assign urgent_o   = |hit;
  assign new_pend_o = |(irq_pend_i & ~pend_q);
endmodule

// File: rtl/swk_evt_latch.sv
module swk_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // clearing wins: an event consumed in the same cycle is not kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/swk_seq.sv
module swk_seq
  import swk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_irq_i,
  input  logic wait_evt_i,
  input  logic exc_ret_i,
  input  logic auto_sleep_en_i,
  input  logic any_pend_i,
  input  logic latch_i,
  input  logic ev_now_i,
  input  logic urgent_i,
  input  logic dbg_halt_i,
  input  logic irq_hold_i,
  output logic consume_o,
  output logic sleeping_o,
  output logic wake_o,
  output logic take_o
);
  swk_state_e st_q, st_d;
  logic wake_d, take_d, take_ok;

  assign take_ok = urgent_i & ~irq_hold_i & ~dbg_halt_i;

  always_comb begin
    st_d      = st_q;
    wake_d    = 1'b0;
    take_d    = 1'b0;
    consume_o = 1'b0;
    case (st_q)
      ST_AWAKE: begin
        if (wait_irq_i) begin
          st_d = ST_SLP_IRQ;
        end else if (wait_evt_i) begin
          if (latch_i | ev_now_i) consume_o = 1'b1;
          else                    st_d      = ST_SLP_EVT;
        end else if (exc_ret_i & auto_sleep_en_i & ~any_pend_i) begin
          st_d = ST_SLP_IRQ;
        end
      end
      ST_SLP_IRQ: begin
        if (urgent_i | dbg_halt_i) begin
          st_d   = ST_AWAKE;
          wake_d = 1'b1;
          take_d = take_ok;
        end
      end
      ST_SLP_EVT: begin
        if (ev_now_i) begin
          st_d      = ST_AWAKE;
          wake_d    = 1'b1;
          take_d    = take_ok;
          consume_o = 1'b1;
        end
      end
      default: st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_AWAKE;
      wake_o <= 1'b0;
      take_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_o <= wake_d;
      take_o <= take_d;
    end
  end

  assign sleeping_o = (st_q != ST_AWAKE);
endmodule

// File: rtl/swk_ctrl.sv
module swk_ctrl #(
  parameter int NIRQ = 4,
  parameter int PW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wait_irq_i,
  input  logic               wait_evt_i,
  input  logic               send_evt_i,
  input  logic               exc_entry_i,
  input  logic               exc_ret_i,
  input  logic [NIRQ-1:0]    irq_pend_i,
  input  logic [NIRQ*PW-1:0] irq_prio_i,
  input  logic               in_handler_i,
  input  logic [PW-1:0]      cur_prio_i,
  input  logic               irq_hold_i,
  input  logic               pend_evt_en_i,
  input  logic               auto_sleep_en_i,
  input  logic               dbg_halt_i,
  input  logic               ext_evt_i,
  output logic               sleeping_o,
  output logic               wake_o,
  output logic               take_irq_o,
  output logic               evt_latch_o
);
  logic urgent, new_pend, ev_now, consume;

  swk_irq_qual #(.NIRQ(NIRQ), .PW(PW)) u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_pend_i   (irq_pend_i),
    .irq_prio_i   (irq_prio_i),
    .in_handler_i (in_handler_i),
    .cur_prio_i   (cur_prio_i),
    .urgent_o     (urgent),
    .new_pend_o   (new_pend)
  );

  assign ev_now = send_evt_i | ext_evt_i | dbg_halt_i | exc_entry_i |
                  exc_ret_i | urgent | (pend_evt_en_i & new_pend);

  swk_evt_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_now),
    .clr_i (consume),
    .q_o   (evt_latch_o)
  );

  swk_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .wait_irq_i      (wait_irq_i),
    .wait_evt_i      (wait_evt_i),
    .exc_ret_i       (exc_ret_i),
    .auto_sleep_en_i (auto_sleep_en_i),
    .any_pend_i      (|irq_pend_i),
    .latch_i         (evt_latch_o),
    .ev_now_i        (ev_now),
    .urgent_i        (urgent),
    .dbg_halt_i      (dbg_halt_i),
    .irq_hold_i      (irq_hold_i),
    .consume_o       (consume),
    .sleeping_o      (sleeping_o),
    .wake_o          (wake_o),
    .take_o          (take_irq_o)
  );
endmodule

// File: rtl/swk_ctrl_chk.sv
module swk_ctrl_chk #(
  parameter int NIRQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wait_irq_i,
  input logic            wait_evt_i,
  input logic            send_evt_i,
  input logic            exc_entry_i,
  input logic            exc_ret_i,
  input logic [NIRQ-1:0] irq_pend_i,
  input logic            irq_hold_i,
  input logic            dbg_halt_i,
  input logic            ext_evt_i,
  input logic            sleeping_o,
  input logic            wake_o,
  input logic            take_irq_o,
  input logic            evt_latch_o
);
  // R9
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R9
  wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!sleeping_o && $past(sleeping_o)));

  // R9
  take_with_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> wake_o);

  // R3
  evt_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping_o && wait_evt_i && !wait_irq_i && evt_latch_o)
    |=> (!sleeping_o && !evt_latch_o));

  // R4
  evt_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping_o && wait_evt_i && !wait_irq_i && !evt_latch_o &&
     !send_evt_i && !ext_evt_i && !dbg_halt_i && !exc_entry_i &&
     !exc_ret_i && (irq_pend_i == '0))
    |=> sleeping_o);

  // R10
  dbg_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping_o && dbg_halt_i) |=> (wake_o && !take_irq_o));

  // R7
  hold_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping_o && irq_hold_i) |=> !take_irq_o);
endmodule

bind swk_ctrl swk_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wait_irq_i  (wait_irq_i),
  .wait_evt_i  (wait_evt_i),
  .send_evt_i  (send_evt_i),
  .exc_entry_i (exc_entry_i),
  .exc_ret_i   (exc_ret_i),
  .irq_pend_i  (irq_pend_i),
  .irq_hold_i  (irq_hold_i),
  .dbg_halt_i  (dbg_halt_i),
  .ext_evt_i   (ext_evt_i),
  .sleeping_o  (sleeping_o),
  .wake_o      (wake_o),
  .take_irq_o  (take_irq_o),
  .evt_latch_o (evt_latch_o)
);

// File: tb/sim_swk_ctrl.sv
module sim_swk_ctrl;
  localparam int CLK_P = 10;
  localparam int NIRQ  = 4;
  localparam int PW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_irq_i = 0, wait_evt_i = 0, send_evt_i = 0, exc_entry_i = 0, exc_ret_i = 0;
  logic [NIRQ-1:0]    irq_pend_i = '0;
  logic [NIRQ*PW-1:0] irq_prio_i = '0;
  logic in_handler_i = 0;
  logic [PW-1:0] cur_prio_i = '0;
  logic irq_hold_i = 0, pend_evt_en_i = 0, auto_sleep_en_i = 0, dbg_halt_i = 0, ext_evt_i = 0;
  logic sleeping_o, wake_o, take_irq_o, evt_latch_o;

  swk_ctrl #(.NIRQ(NIRQ), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wait_irq_i(wait_irq_i), .wait_evt_i(wait_evt_i), .send_evt_i(send_evt_i),
    .exc_entry_i(exc_entry_i), .exc_ret_i(exc_ret_i),
    .irq_pend_i(irq_pend_i), .irq_prio_i(irq_prio_i),
    .in_handler_i(in_handler_i), .cur_prio_i(cur_prio_i),
    .irq_hold_i(irq_hold_i), .pend_evt_en_i(pend_evt_en_i),
    .auto_sleep_en_i(auto_sleep_en_i), .dbg_halt_i(dbg_halt_i), .ext_evt_i(ext_evt_i),
    .sleeping_o(sleeping_o), .wake_o(wake_o), .take_irq_o(take_irq_o),
    .evt_latch_o(evt_latch_o)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    string tag;
    logic  s, w, t, l;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic compare(exp_t e);
    n_chk++;
    if (sleeping_o !== e.s || wake_o !== e.w || take_irq_o !== e.t || evt_latch_o !== e.l) begin
      n_fail++;
      $display("FAIL %s: got sleep=%b wake=%b take=%b latch=%b, expected %b %b %b %b",
               e.tag, sleeping_o, wake_o, take_irq_o, evt_latch_o, e.s, e.w, e.t, e.l);
    end
  endtask

  // monitor: one item per rising edge, popped one time unit later
  always @(posedge clk) begin : mon
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      compare(e);
    end
  end

  task automatic now_chk(string tag, logic s, logic w, logic t, logic l);
    exp_t e;
    e.tag = tag; e.s = s; e.w = w; e.t = t; e.l = l;
    compare(e);
  endtask

  // driver: queue the result due at the next edge, then clear strobes
  task automatic step(string tag, logic s, logic w, logic t, logic l);
    exp_t e;
    e.tag = tag; e.s = s; e.w = w; e.t = t; e.l = l;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    wait_irq_i = 0; wait_evt_i = 0; send_evt_i = 0;
    exc_entry_i = 0; exc_ret_i = 0; ext_evt_i = 0;
  endtask

  task automatic set_irq(int i, logic p, logic [PW-1:0] pr);
    irq_pend_i[i] = p;
    irq_prio_i[i*PW +: PW] = pr;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    now_chk("R1 in reset", 0, 0, 0, 0);
    rst_n = 1;
    step("R1 after reset", 0, 0, 0, 0);

    // R2 event sources
    send_evt_i = 1;  step("R2 send event", 0, 0, 0, 1);
    // R3 skip on set latch
    wait_evt_i = 1;  step("R3 latch consumed", 0, 0, 0, 0);
    exc_entry_i = 1; step("R2 exception entry", 0, 0, 0, 1);
    wait_evt_i = 1;  step("R3 latch consumed again", 0, 0, 0, 0);
    // R4 event sleep
    wait_evt_i = 1;  step("R4 enter event sleep", 1, 0, 0, 0);
    step("R4 stays asleep", 1, 0, 0, 0);
    ext_evt_i = 1;   step("R4 external event wakes", 0, 1, 0, 0);
    step("R9 wake one cycle", 0, 0, 0, 0);
    // R3 same-cycle event
    wait_evt_i = 1; ext_evt_i = 1; step("R3 same cycle event", 0, 0, 0, 0);

    // R5 interrupt sleep rules
    in_handler_i = 1; cur_prio_i = 2'd1;
    wait_irq_i = 1;  step("R5 enter irq sleep", 1, 0, 0, 0);
    set_irq(0, 1, 2'd1); step("R5 same priority no wake", 1, 0, 0, 0);
    set_irq(1, 1, 2'd2); step("R5 lower priority no wake", 1, 0, 0, 0);
    ext_evt_i = 1;   step("R5 event sets latch only", 1, 0, 0, 1);
    set_irq(2, 1, 2'd0); step("R7 urgent wakes and takes", 0, 1, 1, 1);
    step("R9 after urgent wake", 0, 0, 0, 1);
    set_irq(2, 0, 2'd0);

    // R6 pend event
    pend_evt_en_i = 1;
    wait_evt_i = 1;  step("R6 consume old latch", 0, 0, 0, 0);
    wait_evt_i = 1;  step("R6 enter event sleep", 1, 0, 0, 0);
    set_irq(3, 1, 2'd3); step("R6 new low pend wakes no take", 0, 1, 0, 0);
    step("R6 after wake", 0, 0, 0, 0);

    // R7 hold
    irq_hold_i = 1;
    wait_irq_i = 1;  step("R7 enter irq sleep held", 1, 0, 0, 0);
    set_irq(2, 1, 2'd0); step("R7 held wake no take", 0, 1, 0, 1);
    step("R7 after held wake", 0, 0, 0, 1);
    set_irq(2, 0, 2'd0); irq_hold_i = 0;

    // R10 debug halt
    wait_evt_i = 1;  step("R10 consume latch", 0, 0, 0, 0);
    wait_evt_i = 1;  step("R10 enter event sleep", 1, 0, 0, 0);
    dbg_halt_i = 1;  step("R10 debug ends event sleep", 0, 1, 0, 0);
    dbg_halt_i = 0;  step("R10 idle", 0, 0, 0, 0);
    wait_irq_i = 1;  step("R10 enter irq sleep", 1, 0, 0, 0);
    dbg_halt_i = 1;  step("R10 debug ends irq sleep", 0, 1, 0, 1);
    dbg_halt_i = 0;  step("R10 idle after", 0, 0, 0, 1);

    // R8 auto sleep on return
    auto_sleep_en_i = 1;
    exc_ret_i = 1;   step("R8 pending keeps awake", 0, 0, 0, 1);
    irq_pend_i = '0;
    exc_ret_i = 1;   step("R8 return enters sleep", 1, 0, 0, 1);
    in_handler_i = 0;
    set_irq(1, 1, 2'd2); step("R8 thread mode wake takes", 0, 1, 1, 1);
    step("R8 after wake", 0, 0, 0, 1);
    irq_pend_i = '0; auto_sleep_en_i = 0;

    // R11 async reset
    wait_evt_i = 1;  step("R11 consume latch", 0, 0, 0, 0);
    wait_evt_i = 1;  step("R11 enter sleep", 1, 0, 0, 0);
    rst_n = 0;
    #1;
    now_chk("R11 async reset wakes", 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1;
    step("R1 after second reset", 0, 0, 0, 0);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule